// File: doc/BRIEF.md
# Single-Cell Lithium Charge Cycle Sequencer

This block is the digital controller that steps a single-cell lithium battery through one charge cycle. It does not see any analog signals. It works on comparator results that are already digital: battery below the pre-charge threshold, battery below the top-up threshold, constant-voltage regulation reached, charge current tapered under one tenth of its programmed level, thermistor hot, thermistor cold, thermistor monitoring disabled, shutdown, input suspend and input supply good. A periodic timebase pulse sets the pace of every timing window, and each window length is a parameter counted in pulses. A window can therefore be scaled down for simulation.

A cycle begins in one of two modes. If the cell is deeply discharged it starts in reduced-current pre-charge; otherwise it starts in full constant-current charging. Once the analog loop reports constant-voltage regulation, a safety window opens, and charging ends when that window runs out. After termination the sequencer watches for a sustained sag below the top-up threshold, and such a sag starts a fresh cycle. A thermistor excursion pauses charging and freezes the running window at its current value. A pre-charge that lasts too long latches a dead-cell fault, which stays set until the supply is re-qualified or shutdown is requested.

Top module: `li_charge_seq`

## Requirements
- R1: While `rst` is high, and afterwards while the input supply is not good, every output is low and charging is off.
- R2: When a cycle starts with `bat_low_i` high, the sequencer enters pre-charge with `chg_en_o`, `trickle_o` and `chg_stat_o` all high.
- R3: If pre-charge lasts for `TRK_TICKS` timebase pulses, charging stops, `bad_bat_o` goes high and `chg_stat_o` goes low. After `TRK_TICKS`-1 pulses, pre-charge is still active.
- R4: Pre-charge hands over to full-current charging (`trickle_o` low, `chg_en_o` high) once `bat_low_i` falls. A cycle that starts with `bat_low_i` low goes straight to full-current charging.
- R5: During full-current charging no window runs. Once `cv_reached_i` is high, charging continues for exactly `SAFE_TICKS` pulses and then `chg_en_o` and `chg_stat_o` drop.
- R6: In constant-voltage charging, `taper_i` pulls `chg_stat_o` low while `chg_en_o` stays high until the safety window runs out.
- R7: After termination, a new cycle starts only when `below_rchg_i` stays high across `RCHG_TICKS` timebase pulses. A shorter excursion leaves charging off.
- R8: A qualified top-up event during constant-voltage charging restarts the safety window from zero.
- R9: A hot or cold thermistor flag during a charging phase raises `temp_hold_o`, drops `chg_en_o` and freezes the running window. When the flag clears, the window resumes from the value it held.
- R10: While `ntc_off_i` is high, the hot and cold flags have no effect on charging or on `temp_hold_o`.
- R11: `chg_stat_o` is low during suspend, during shutdown and while the supply is not good. Suspend also drops `chg_en_o` and freezes the window.
- R12: When a qualified top-up event and the end of the safety window fall in the same cycle, the window restart wins and charging continues.
- R13: `bad_bat_o` stays high regardless of the battery flags until `shdn_i` is raised or the supply good flag drops and returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase pulse, synchronous to clk |
| bat_low_i | input | 1 | Battery below pre-charge threshold (asynchronous) |
| below_rchg_i | input | 1 | Battery below top-up threshold (asynchronous) |
| cv_reached_i | input | 1 | Constant-voltage regulation reached (asynchronous) |
| taper_i | input | 1 | Charge current under one tenth of programmed value (asynchronous) |
| ntc_hot_i | input | 1 | Thermistor hot fault (asynchronous) |
| ntc_cold_i | input | 1 | Thermistor cold fault (asynchronous) |
| ntc_off_i | input | 1 | Thermistor monitoring disabled (asynchronous) |
| shdn_i | input | 1 | Shutdown request (asynchronous) |
| susp_i | input | 1 | Input suspend (asynchronous) |
| uvlo_ok_i | input | 1 | Input supply above lockout (asynchronous) |
| chg_en_o | output | 1 | Charge current enable |
| trickle_o | output | 1 | Reduced pre-charge current select |
| chg_stat_o | output | 1 | Charging-in-progress status |
| bad_bat_o | output | 1 | Latched dead-cell fault |
| temp_hold_o | output | 1 | Charging paused for temperature |

## Verification
Two functions can land in the same clock: the top-up qualifier firing and the safety window reaching its limit. The bench provokes this by advancing the window to three pulses short of its limit. It then raises the top-up flag, so that the third qualifying pulse also brings the window count to the limit. It judges the outcome by checking that charging is still enabled afterwards. A further `SAFE_TICKS` pulses are then needed before termination, which shows that the window restarted from zero rather than expiring.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TRICKLE = 3'd1,
    ST_BULK    = 3'd2,
    ST_CV      = 3'd3,
    ST_DONE    = 3'd4,
    ST_FAULT   = 3'd5
  } chg_state_t;

  typedef struct packed {
    logic bat_low;
    logic below_rchg;
    logic cv;
    logic taper;
    logic hot;
    logic cold;
    logic ntc_off;
    logic shdn;
    logic susp;
    logic uvlo_ok;
  } chg_flags_t;

  localparam int NUM_FLAGS = $bits(chg_flags_t);

  function automatic logic is_charging(chg_state_t s);
    return (s == ST_TRICKLE) || (s == ST_BULK) || (s == ST_CV);
  endfunction

endpackage

// File: rtl/chg_flag_sync.sv
module chg_flag_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/chg_rchg_filter.sv
module chg_rchg_filter #(
  parameter int QUAL_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic flag_i,
  output logic evt_o
);

  localparam int CW = $clog2(QUAL_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (!flag_i) begin
        cnt_q <= '0;
      end else if (tick_i && (cnt_q < CW'(QUAL_TICKS))) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(QUAL_TICKS - 1)) evt_q <= 1'b1;
      end
    end
  end

  assign evt_o = evt_q;

  AST_EVT_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q); // R7

  AST_EVT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !flag_i |=> !evt_q); // R7

endmodule

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (run_i && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !run_i) |=> $stable(cnt_q)); // R9

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && run_i && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5

endmodule

// File: rtl/li_charge_seq.sv
module li_charge_seq
  import chg_seq_pkg::*;
#(
  parameter int TRK_TICKS   = 8,
  parameter int SAFE_TICKS  = 12,
  parameter int RCHG_TICKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic bat_low_i,
  input  logic below_rchg_i,
  input  logic cv_reached_i,
  input  logic taper_i,
  input  logic ntc_hot_i,
  input  logic ntc_cold_i,
  input  logic ntc_off_i,
  input  logic shdn_i,
  input  logic susp_i,
  input  logic uvlo_ok_i,
  output logic chg_en_o,
  output logic trickle_o,
  output logic chg_stat_o,
  output logic bad_bat_o,
  output logic temp_hold_o
);

  localparam int TMAX = (TRK_TICKS > SAFE_TICKS) ? TRK_TICKS : SAFE_TICKS;
  localparam int TW   = $clog2(TMAX + 2);

  chg_flags_t raw, fs;

  always_comb begin
    raw.bat_low    = bat_low_i;
    raw.below_rchg = below_rchg_i;
    raw.cv         = cv_reached_i;
    raw.taper      = taper_i;
    raw.hot        = ntc_hot_i;
    raw.cold       = ntc_cold_i;
    raw.ntc_off    = ntc_off_i;
    raw.shdn       = shdn_i;
    raw.susp       = susp_i;
    raw.uvlo_ok    = uvlo_ok_i;
  end

  chg_flag_sync #(.W(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (fs)
  );

  logic rchg_evt;

  chg_rchg_filter #(.QUAL_TICKS(RCHG_TICKS)) u_rchg (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .flag_i (fs.below_rchg),
    .evt_o  (rchg_evt)
  );

  chg_state_t   state_q, state_d;
  logic [TW-1:0] tmr_cnt;
  logic          tmr_clr, tmr_run;
  logic          pwr_ok, temp_bad, start_trk, trk_exp, safe_exp;
  logic          eoc_q, eoc_d;

  assign pwr_ok    = fs.uvlo_ok && !fs.shdn;
  assign temp_bad  = !fs.ntc_off && (fs.hot || fs.cold);
  assign start_trk = fs.bat_low;
  assign trk_exp   = (tmr_cnt >= TW'(TRK_TICKS));
  assign safe_exp  = (tmr_cnt >= TW'(SAFE_TICKS));

  always_comb begin
    state_d = state_q;
    if (!pwr_ok) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = start_trk ? ST_TRICKLE : ST_BULK;
        ST_TRICKLE: begin
          if (!fs.susp) begin
            if (!fs.bat_low)     state_d = ST_BULK;
            else if (trk_exp)    state_d = ST_FAULT;
          end
        end
        ST_BULK: begin
          if (!fs.susp && fs.cv) state_d = ST_CV;
        end
        ST_CV: begin
          if (!fs.susp && !rchg_evt && safe_exp) state_d = ST_DONE;
        end
        ST_DONE: begin
          if (rchg_evt) state_d = start_trk ? ST_TRICKLE : ST_BULK;
        end
        ST_FAULT: state_d = ST_FAULT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign tmr_clr = (state_d != state_q) || ((state_q == ST_CV) && rchg_evt);
  assign tmr_run = tick_i && ((state_q == ST_TRICKLE) || (state_q == ST_CV))
                   && !temp_bad && !fs.susp;

  chg_tick_timer #(.W(TW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr_i (tmr_clr),
    .run_i (tmr_run),
    .cnt_o (tmr_cnt)
  );

  assign eoc_d = (state_d == ST_CV) &&
                 (eoc_q || ((state_q == ST_CV) && fs.taper));

  logic en_q, trk_q, stat_q, bad_q, hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      eoc_q   <= 1'b0;
      en_q    <= 1'b0;
      trk_q   <= 1'b0;
      stat_q  <= 1'b0;
      bad_q   <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      eoc_q   <= eoc_d;
      en_q    <= is_charging(state_d) && !temp_bad && !fs.susp;
      trk_q   <= (state_d == ST_TRICKLE) && !temp_bad && !fs.susp;
      stat_q  <= is_charging(state_d) && !eoc_d && !fs.susp;
      bad_q   <= (state_d == ST_FAULT);
      hold_q  <= is_charging(state_d) && temp_bad;
    end
  end

  assign chg_en_o    = en_q;
  assign trickle_o   = trk_q;
  assign chg_stat_o  = stat_q;
  assign bad_bat_o   = bad_q;
  assign temp_hold_o = hold_q;

  AST_FAULT_NO_CHARGE: assert property (@(posedge clk) disable iff (rst)
    bad_q |-> !en_q); // R3

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (bad_q && fs.uvlo_ok && !fs.shdn) |=> bad_q); // R13

  AST_SUSP_STAT_LOW: assert property (@(posedge clk) disable iff (rst)
    fs.susp |=> (!stat_q && !en_q)); // R11

  AST_NOPWR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> (!en_q && !stat_q && !bad_q)); // R11

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (temp_bad && is_charging(state_q)) |=> !en_q); // R9

  AST_NTC_BYPASS: assert property (@(posedge clk) disable iff (rst)
    fs.ntc_off |=> !hold_q); // R10

  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_CV) && rchg_evt && pwr_ok) |=> (state_q == ST_CV)); // R12

endmodule

// File: tb/tb_li_charge_seq.sv
`timescale 1ns/1ps
module tb_li_charge_seq;

  localparam int TRK  = 8;
  localparam int SAFE = 12;
  localparam int QUAL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, bat_low = 0, below_rchg = 0, cv = 0, taper = 0;
  logic hot = 0, cold = 0, ntc_off = 0, shdn = 0, susp = 0, uvlo_ok = 0;
  logic chg_en, trickle, stat, bad, hold;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  li_charge_seq #(.TRK_TICKS(TRK), .SAFE_TICKS(SAFE), .RCHG_TICKS(QUAL)) dut (
    .clk(clk), .rst(rst), .tick_i(tick),
    .bat_low_i(bat_low), .below_rchg_i(below_rchg), .cv_reached_i(cv),
    .taper_i(taper), .ntc_hot_i(hot), .ntc_cold_i(cold), .ntc_off_i(ntc_off),
    .shdn_i(shdn), .susp_i(susp), .uvlo_ok_i(uvlo_ok),
    .chg_en_o(chg_en), .trickle_o(trickle), .chg_stat_o(stat),
    .bad_bat_o(bad), .temp_hold_o(hold)
  );

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      w(2);
    end
    w(4);
  endtask

  // outputs packed {chg_en, trickle, stat, bad, hold}
  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] got;
    got = {chg_en, trickle, stat, bad, hold};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got en,trk,stat,bad,hold=%b expected %b", req, got, exp);
    end
  endtask

  task automatic qualify_rchg();
    below_rchg = 1'b1; w(5);
    ticks(QUAL);
    below_rchg = 1'b0; w(5);
  endtask

  initial begin
    w(5);
    check("R1 reset", 5'b00000);
    rst = 1'b0; w(5);
    check("R1 no supply", 5'b00000);

    // pre-charge start and timeout
    bat_low = 1'b1; uvlo_ok = 1'b1; w(5);
    check("R2 precharge start", 5'b11100);
    ticks(TRK - 1);
    check("R3 before timeout", 5'b11100);
    ticks(1);
    check("R3 timeout fault", 5'b00010);
    bat_low = 1'b0; w(5);
    check("R13 fault sticky", 5'b00010);
    shdn = 1'b1; w(5);
    check("R13 shutdown clears", 5'b00000);
    shdn = 1'b0; w(5);
    check("R4 start in bulk", 5'b10100);

    // fault cleared by supply requalification
    uvlo_ok = 1'b0; bat_low = 1'b1; w(5);
    check("R11 supply lost", 5'b00000);
    uvlo_ok = 1'b1; w(5);
    ticks(TRK);
    check("R3 second fault", 5'b00010);
    uvlo_ok = 1'b0; w(5);
    uvlo_ok = 1'b1; w(5);
    check("R13 requalify clears", 5'b11100);
    ticks(4);
    bat_low = 1'b0; w(5);
    check("R4 precharge to bulk", 5'b10100);

    // bulk has no window, then CV window
    ticks(20);
    check("R5 bulk no window", 5'b10100);
    cv = 1'b1; w(5);
    ticks(SAFE - 1);
    check("R5 before expiry", 5'b10100);
    ticks(1);
    check("R5 expiry", 5'b00000);

    // top-up qualification
    below_rchg = 1'b1; w(5);
    ticks(QUAL - 1);
    below_rchg = 1'b0; w(5);
    check("R7 short excursion ignored", 5'b00000);
    qualify_rchg();
    check("R7 recharge restarts", 5'b10100);

    // taper
    taper = 1'b1; w(5);
    check("R6 taper status low", 5'b10000);
    taper = 1'b0; w(5);

    // temperature hold freezes window
    ticks(5);
    hot = 1'b1; w(5);
    check("R9 hold raised", 5'b00001);
    ticks(20);
    hot = 1'b0; w(5);
    check("R9 hold released", 5'b10000);
    ticks(SAFE - 5 - 1);
    check("R9 resumed window", 5'b10000);
    ticks(1);
    check("R9 frozen then expiry", 5'b00000);

    // thermistor bypass
    qualify_rchg();
    ntc_off = 1'b1; cold = 1'b1; w(5);
    check("R10 bypass", 5'b10100);
    cold = 1'b0; ntc_off = 1'b0; w(5);

    // coincident restart and expiry
    ticks(SAFE - QUAL);
    below_rchg = 1'b1; w(5);
    ticks(QUAL);
    check("R12 restart wins", 5'b10100);
    below_rchg = 1'b0; w(5);
    ticks(SAFE - 1);
    check("R8 window restarted", 5'b10100);
    ticks(1);
    check("R8 expiry after restart", 5'b00000);

    // suspend
    qualify_rchg();
    susp = 1'b1; w(5);
    check("R11 suspend", 5'b00000);
    ticks(20);
    susp = 1'b0; w(5);
    check("R11 resume", 5'b10100);
    ticks(SAFE - 1);
    check("R11 window frozen in suspend", 5'b10100);
    ticks(1);
    check("R5 final expiry", 5'b00000);

    qualify_rchg();
    shdn = 1'b1; w(5);
    check("R11 shutdown status low", 5'b00000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule